// File: doc/BRIEF.md
# Trace Cache Hit and Next-Address Selector

This block is the lookup half of a small direct-mapped trace cache. Every line describes one stored trace: the address the trace starts at, how many conditional branches it holds (zero to three), the direction each internal branch took when the trace was built, a flag telling whether the trace's last instruction is itself a branch, and the two possible continuation addresses (fall-through and target). Instruction storage is kept elsewhere; this block only decides whether a stored trace may be used and where fetch goes next.

Each cycle the front end offers a fetch address together with a vector of branch directions that a history-only predictor produced in parallel for the next few branches. The block indexes one line with the fetch address, checks that the line is valid, that its start address equals the fetch address, and that every internal branch's predicted direction agrees with the recorded one. On a hit, the prediction for a closing branch picks between target and fall-through; a trace without a closing branch always continues at its fall-through. On a miss the block reports so and proposes the next sequential line. The result is registered and appears one cycle after the request. A fill port writes a whole line at the index taken from its start address, replacing whatever was there.

Top module: `tc_trace_lookup`

## Requirements
- R1: After synchronous reset, `res_vld` is 0 and every line is invalid, so the first lookup of any address reports a miss.
- R2: A lookup offered with `fetch_vld` high produces its result with `res_vld` high on the following clock edge; a cycle without a request gives `res_vld` low.
- R3: A hit requires a valid line whose stored start address equals the full fetch address; the line is selected by fetch address bits [8:4], so an address with the same index but a different start address misses.
- R4: `pred_dir[i]` is the prediction for branch i of the trace (bit 0 is the first branch, 1 means taken); each internal branch (the stored branch count, less one when the trace closes with a branch) must have `pred_dir[i]` equal to stored mask bit i, or the lookup misses.
- R5: Stored mask bits and prediction bits at or above the internal branch count take no part in the hit decision.
- R6: On a hit of a trace that closes with a branch and holds at least one branch, `pred_dir[count-1]` equal to 1 selects the target address and 0 selects the fall-through address.
- R7: On a hit of a trace that does not close with a branch, or holds no branch, the next address is the fall-through address whatever the predictions are.
- R8: On a miss, `res_miss` is 1, `res_hit` is 0 and `res_next` is the fetch address plus 16.
- R9: A fill overwrites the line at its index from the next cycle on; a lookup in the same cycle as the fill sees the old line.
- R10: Whenever `res_vld` is high exactly one of `res_hit` and `res_miss` is high; when it is low both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_vld | input | 1 | Lookup request this cycle |
| fetch_addr | input | 32 | Address to look up |
| pred_dir | input | 3 | Parallel predicted directions, bit i for branch i |
| fill_en | input | 1 | Write a line this cycle |
| fill_addr | input | 32 | Start address of the trace being written |
| fill_br_cnt | input | 2 | Number of branches in the trace |
| fill_dir_mask | input | 3 | Recorded directions of the internal branches |
| fill_ends_br | input | 1 | Trace closes with a branch |
| fill_fall_addr | input | 32 | Fall-through continuation address |
| fill_tgt_addr | input | 32 | Taken-target continuation address |
| res_vld | output | 1 | Result of last cycle's lookup is present |
| res_hit | output | 1 | Stored trace may be used |
| res_miss | output | 1 | No usable trace |
| res_next | output | 32 | Next fetch address |

## Verification
The hardest situation to reach is one where the hit decision depends on bits that must be ignored: a line whose closing branch sits in the mask position, or whose count stops short of set mask bits, looked up with predictions that disagree only in those positions. The stimulus fills lines with deliberately inconsistent high mask bits and then sweeps predictions that differ from the mask only above the internal count, alongside ones that differ inside it. A second hard case is a fill and a lookup of the same line in one cycle; the bench issues both in one cycle and then repeats the lookup to see the old and the new contents in turn.

// File: rtl/tc_pkg.sv
package tc_pkg;

    parameter int ADDR_W     = 32;
    parameter int LINES      = 32;
    parameter int MAX_BR     = 3;
    parameter int LINE_BYTES = 16;

    localparam int IDX_W = $clog2(LINES);
    localparam int OFS_W = $clog2(LINE_BYTES);
    localparam int CNT_W = $clog2(MAX_BR + 1);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [MAX_BR-1:0] dir_t;

    typedef struct packed {
        addr_t start;
        cnt_t  br_cnt;
        dir_t  dir_mask;
        logic  ends_br;
        addr_t fall_addr;
        addr_t tgt_addr;
    } trace_line_t;

    typedef struct packed {
        logic  hit;
        addr_t next_addr;
    } lookup_t;

    function automatic idx_t line_index(addr_t a);
        return a[OFS_W +: IDX_W];
    endfunction

    // Branches whose direction is part of the hit decision.
    function automatic cnt_t inner_count(trace_line_t l);
        if (l.ends_br && (l.br_cnt != '0))
            return l.br_cnt - cnt_t'(1);
        return l.br_cnt;
    endfunction

    function automatic addr_t seq_next(addr_t a);
        return a + addr_t'(LINE_BYTES);
    endfunction

endpackage

// File: rtl/tc_line_store.sv
module tc_line_store
    import tc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  idx_t        wr_idx,
    input  trace_line_t wr_line,
    input  idx_t        rd_idx,
    output trace_line_t rd_line,
    output logic        rd_valid
);
    trace_line_t      lines_q [LINES];
    logic [LINES-1:0] valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            lines_q[wr_idx] <= wr_line;
        end
    end

    assign rd_line  = lines_q[rd_idx];
    assign rd_valid = valid_q[rd_idx];

endmodule

// File: rtl/tc_hit_eval.sv
module tc_hit_eval
    import tc_pkg::*;
(
    input  trace_line_t line,
    input  logic        line_valid,
    input  addr_t       fetch_addr,
    input  dir_t        pred,
    output lookup_t     result
);
    cnt_t inner;
    dir_t agree;
    logic tag_ok;
    logic dirs_ok;
    logic final_taken;

    assign inner  = inner_count(line);
    assign tag_ok = line_valid && (line.start == fetch_addr);

    for (genvar g = 0; g < MAX_BR; g++) begin : g_agree
        assign agree[g] = (cnt_t'(g) >= inner) || (pred[g] == line.dir_mask[g]);
    end

    assign dirs_ok = &agree;

    always_comb begin
        final_taken = 1'b0;
        for (int i = 0; i < MAX_BR; i++) begin
            if (line.br_cnt == cnt_t'(i + 1)) begin
                final_taken = pred[i];
            end
        end
    end

    always_comb begin
        result.hit = tag_ok && dirs_ok;
        if (!result.hit) begin
            result.next_addr = seq_next(fetch_addr);
        end else if (line.ends_br && (line.br_cnt != '0) && final_taken) begin
            result.next_addr = line.tgt_addr;
        end else begin
            result.next_addr = line.fall_addr;
        end
    end

endmodule

// File: rtl/tc_trace_lookup.sv
module tc_trace_lookup
    import tc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        fetch_vld,
    input  logic [31:0] fetch_addr,
    input  logic [2:0]  pred_dir,
    input  logic        fill_en,
    input  logic [31:0] fill_addr,
    input  logic [1:0]  fill_br_cnt,
    input  logic [2:0]  fill_dir_mask,
    input  logic        fill_ends_br,
    input  logic [31:0] fill_fall_addr,
    input  logic [31:0] fill_tgt_addr,
    output logic        res_vld,
    output logic        res_hit,
    output logic        res_miss,
    output logic [31:0] res_next
);
    trace_line_t wr_line;
    trace_line_t rd_line;
    logic        rd_valid;
    lookup_t     comb_res;
    lookup_t     res_q;
    logic        vld_q;

    always_comb begin
        wr_line.start     = fill_addr;
        wr_line.br_cnt    = fill_br_cnt;
        wr_line.dir_mask  = fill_dir_mask;
        wr_line.ends_br   = fill_ends_br;
        wr_line.fall_addr = fill_fall_addr;
        wr_line.tgt_addr  = fill_tgt_addr;
    end

    tc_line_store u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (fill_en),
        .wr_idx   (line_index(fill_addr)),
        .wr_line  (wr_line),
        .rd_idx   (line_index(fetch_addr)),
        .rd_line  (rd_line),
        .rd_valid (rd_valid)
    );

    tc_hit_eval u_eval (
        .line       (rd_line),
        .line_valid (rd_valid),
        .fetch_addr (fetch_addr),
        .pred       (pred_dir),
        .result     (comb_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= fetch_vld;
            if (fetch_vld) begin
                res_q <= comb_res;
            end
        end
    end

    assign res_vld  = vld_q;
    assign res_hit  = vld_q && res_q.hit;
    assign res_miss = vld_q && !res_q.hit;
    assign res_next = res_q.next_addr;

endmodule

// File: rtl/tc_lookup_chk.sv
module tc_lookup_chk
    import tc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        fetch_vld,
    input logic [31:0] fetch_addr,
    input logic        res_vld,
    input logic        res_hit,
    input logic        res_miss,
    input logic [31:0] res_next
);
    // R10
    one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        res_vld |-> ($countones({res_hit, res_miss}) == 1));

    // R10
    quiet_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !res_vld |-> (!res_hit && !res_miss));

    // R2
    req_to_res_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_vld |=> res_vld);

    // R2
    no_req_no_res_chk: assert property (@(posedge clk) disable iff (rst)
        !fetch_vld |=> !res_vld);

    // R8
    miss_seq_addr_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_vld ##1 res_miss |-> (res_next == $past(fetch_addr) + 32'(LINE_BYTES)));

endmodule

bind tc_trace_lookup tc_lookup_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .fetch_vld  (fetch_vld),
    .fetch_addr (fetch_addr),
    .res_vld    (res_vld),
    .res_hit    (res_hit),
    .res_miss   (res_miss),
    .res_next   (res_next)
);

// File: tb/sim_tc_trace_lookup.sv
module sim_tc_trace_lookup;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch_vld = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic [2:0]  pred_dir = '0;
    logic        fill_en = 1'b0;
    logic [31:0] fill_addr = '0;
    logic [1:0]  fill_br_cnt = '0;
    logic [2:0]  fill_dir_mask = '0;
    logic        fill_ends_br = 1'b0;
    logic [31:0] fill_fall_addr = '0;
    logic [31:0] fill_tgt_addr = '0;
    logic        res_vld;
    logic        res_hit;
    logic        res_miss;
    logic [31:0] res_next;

    int checks = 0;
    int errors = 0;

    typedef struct {
        bit          hit;
        logic [31:0] nxt;
        string       req;
    } exp_t;

    exp_t exp_q[$];

    always #2 clk = ~clk;

    tc_trace_lookup u0 (
        .clk(clk), .rst(rst),
        .fetch_vld(fetch_vld), .fetch_addr(fetch_addr), .pred_dir(pred_dir),
        .fill_en(fill_en), .fill_addr(fill_addr), .fill_br_cnt(fill_br_cnt),
        .fill_dir_mask(fill_dir_mask), .fill_ends_br(fill_ends_br),
        .fill_fall_addr(fill_fall_addr), .fill_tgt_addr(fill_tgt_addr),
        .res_vld(res_vld), .res_hit(res_hit), .res_miss(res_miss), .res_next(res_next)
    );

    task automatic fail_line(string req, string what, logic [31:0] act, logic [31:0] exp);
        errors++;
        $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    endtask

    // Monitor: one cycle after each request, pop and compare.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!rst) begin
                if (exp_q.size() != 0) begin
                    exp_t e;
                    e = exp_q.pop_front();
                    checks++;
                    if (res_vld !== 1'b1)
                        fail_line("R2", "res_vld", 32'(res_vld), 32'd1);
                    else if (res_hit !== e.hit || res_miss !== !e.hit)
                        fail_line(e.req, "hit", 32'({res_hit, res_miss}), 32'({e.hit, !e.hit}));
                    else if (res_next !== e.nxt)
                        fail_line(e.req, "next", res_next, e.nxt);
                end else if (res_vld !== 1'b0) begin
                    checks++;
                    fail_line("R2", "unrequested res_vld", 32'(res_vld), 32'd0);
                end
            end
        end
    end

    task automatic do_fill(logic [31:0] a, logic [1:0] cnt, logic [2:0] mask,
                           logic ends, logic [31:0] fall, logic [31:0] tgt);
        @(negedge clk);
        fetch_vld      = 1'b0;
        fill_en        = 1'b1;
        fill_addr      = a;
        fill_br_cnt    = cnt;
        fill_dir_mask  = mask;
        fill_ends_br   = ends;
        fill_fall_addr = fall;
        fill_tgt_addr  = tgt;
    endtask

    // keep_fill: issue in the same cycle as the preceding fill.
    task automatic do_fetch(logic [31:0] a, logic [2:0] p, bit hit,
                            logic [31:0] nxt, string req, bit keep_fill = 1'b0);
        exp_t e;
        if (!keep_fill) begin
            @(negedge clk);
            fill_en = 1'b0;
        end
        fetch_vld  = 1'b1;
        fetch_addr = a;
        pred_dir   = p;
        e.hit = hit;
        e.nxt = nxt;
        e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic go_idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            fetch_vld = 1'b0;
            fill_en   = 1'b0;
        end
    endtask

    initial begin
        #80000;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (res_vld !== 1'b0) fail_line("R1", "res_vld in reset", 32'(res_vld), 32'd0);
        @(negedge clk);
        rst = 1'b0;

        // R1 / R8: empty cache misses
        do_fetch(32'h0000_0100, 3'b000, 1'b0, 32'h0000_0110, "R1");
        do_fetch(32'h0000_1040, 3'b111, 1'b0, 32'h0000_1050, "R8");

        // Line at index 4: three branches, closing branch, internal mask 2'b11
        do_fill(32'h0000_1040, 2'd3, 3'b011, 1'b1, 32'h0000_2000, 32'h0000_3000);
        do_fetch(32'h0000_1040, 3'b111, 1'b1, 32'h0000_3000, "R6");
        do_fetch(32'h0000_1040, 3'b011, 1'b1, 32'h0000_2000, "R6");
        do_fetch(32'h0000_1040, 3'b101, 1'b0, 32'h0000_1050, "R4");
        do_fetch(32'h0000_1040, 3'b110, 1'b0, 32'h0000_1050, "R4");
        // R3: same index, different start address
        do_fetch(32'h0000_1240, 3'b111, 1'b0, 32'h0000_1250, "R3");

        // R2: idle gap yields no result
        go_idle(2);

        // Line at index 8: one internal branch (not taken), no closing branch
        do_fill(32'h0000_5080, 2'd1, 3'b110, 1'b0, 32'h0000_6000, 32'h0000_7000);
        do_fetch(32'h0000_5080, 3'b000, 1'b1, 32'h0000_6000, "R5");
        do_fetch(32'h0000_5080, 3'b110, 1'b1, 32'h0000_6000, "R7");
        do_fetch(32'h0000_5080, 3'b001, 1'b0, 32'h0000_5090, "R4");

        // Line at index 12: two branches, closing one; internal mask bit0=1,
        // mask bit1 (closing) set opposite to a taken prediction
        do_fill(32'h0000_90C0, 2'd2, 3'b101, 1'b1, 32'h0000_A000, 32'h0000_B000);
        do_fetch(32'h0000_90C0, 3'b011, 1'b1, 32'h0000_B000, "R5");
        do_fetch(32'h0000_90C0, 3'b001, 1'b1, 32'h0000_A000, "R6");
        do_fetch(32'h0000_90C0, 3'b000, 1'b0, 32'h0000_90D0, "R4");

        // Line at index 16: no branches, closing flag set but meaningless
        do_fill(32'h0000_A100, 2'd0, 3'b111, 1'b1, 32'h0000_C000, 32'h0000_D000);
        do_fetch(32'h0000_A100, 3'b111, 1'b1, 32'h0000_C000, "R7");
        do_fetch(32'h0000_A100, 3'b000, 1'b1, 32'h0000_C000, "R7");

        // R9: overwrite index 4 with a lookup in the same cycle
        do_fill(32'h0000_1240, 2'd0, 3'b000, 1'b0, 32'h0000_4444, 32'h0000_5555);
        do_fetch(32'h0000_1040, 3'b111, 1'b1, 32'h0000_3000, "R9", 1'b1);
        do_fetch(32'h0000_1240, 3'b010, 1'b1, 32'h0000_4444, "R9");
        do_fetch(32'h0000_1040, 3'b111, 1'b0, 32'h0000_1050, "R9");
        // R3: other lines untouched by the overwrite
        do_fetch(32'h0000_5080, 3'b000, 1'b1, 32'h0000_6000, "R3");

        // R1: reset invalidates all lines
        go_idle(1);
        rst = 1'b1;
        go_idle(2);
        rst = 1'b0;
        do_fetch(32'h0000_5080, 3'b000, 1'b0, 32'h0000_5090, "R1");

        go_idle(4);
        checks++;
        if (exp_q.size() != 0) fail_line("R2", "results outstanding", 32'(exp_q.size()), 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule